// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block produces the offset code that spreads a master oscillator's frequency below its nominal value. It runs on the master clock. While spreading is enabled, the code follows a symmetric triangle. The code rises from zero to a peak and falls back to zero. One full up-and-down pass lasts 2048 master clock cycles. A frequency-control stage subtracts the code from its nominal setting. The offset therefore only ever lowers the frequency and never raises it.

A single select input sets the peak depth. A value of 1 selects the shallow 2% spread and a value of 0 selects the deep 4% spread. One code LSB stands for 4%/2048 of nominal. A new select value is taken up only where the triangle passes through zero, or while spreading is off, so the depth never steps in mid-ramp. When the enable input is low, the code drops to zero on the next clock and the triangle restarts from its beginning. A one-cycle strobe marks each crest so that the period can be measured.

The block generates only the offset. It changes the oscillator's frequency alone, so the duty cycle of the clock that follows is untouched.

Top module: `dither_tri_gen`

## Requirements
- R1: While reset is asserted (synchronous, active low), `offset_code` is 0 and `peak_stb` is 0 after the next clock edge.
- R2: While `spread_en` stays high, each clock moves a triangle position one unit. Starting from 0, the position rises for 1024 clocks to its crest of 1024, then falls for 1024 clocks. The pattern repeats every 2048 clocks: 1, 2, ..., 1024, 1023, ..., 1, 0, 1, ...
- R3: With the active depth at 0 (4%), `offset_code` equals twice the triangle position. The step is 2 per clock and the crest is 2048.
- R4: With the active depth at 1 (2%), `offset_code` equals the triangle position. The step is 1 per clock and the crest is 1024.
- R5: `offset_code` is never above the crest of the active depth, and it is 0 at the zero point of every period. The offset is one-sided.
- R6: A clock edge that samples `spread_en` low sets `offset_code` to 0 and restarts the triangle. The first enabled edge afterwards gives position 1.
- R7: `depth_narrow` is taken into the active depth only on an edge that samples `spread_en` low, or on the edge where the triangle returns to position 0. A change at any other time has no effect on `offset_code` until the next zero point.
- R8: `peak_stb` is high for exactly the one cycle in which `offset_code` holds the crest value. In continuous operation it recurs every 2048 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spread_en | input | 1 | High enables the triangle dither |
| depth_narrow | input | 1 | Depth select: 1 gives 2% peak, 0 gives 4% peak |
| offset_code | output | 12 | Unsigned frequency offset to subtract from nominal |
| peak_stb | output | 1 | One-cycle pulse at each triangle crest |

## Verification
The assertions take `spread_en` and `depth_narrow` to be synchronous to the master clock and stable around its rising edge. The step check also relies on the enable staying high across the edge being judged. The bench meets this by changing both inputs only on the falling edge. It changes the depth select at arbitrary phases, including mid-ramp and directly after a crest, so the deferred take-up at the zero point is exercised. It also drops the enable in the middle of ramps to force restarts from position zero.

// File: rtl/dither_pkg.sv
// Shared types for the triangle dither generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dither_pkg;

    // Depth select encoding, as seen on the depth_narrow pin
    typedef enum logic {
        DEPTH_WIDE   = 1'b0,   // 4% peak spread
        DEPTH_NARROW = 1'b1    // 2% peak spread
    } depth_e;

endpackage

// File: rtl/dither_phase_ctr.sv
// Phase counter of the triangle: counts 0..2*HALF_LEN-1 while enabled and
// returns to 0 when disabled. It also raises a one-cycle strobe on the edge
// that lands on the crest phase.
// Assumes: HALF_LEN is a power of two; spread_en is synchronous to clk.
module dither_phase_ctr #(
    parameter int HALF_LEN = 1024,
    localparam int PHASE_W = $clog2(2 * HALF_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spread_en,
    output logic [PHASE_W-1:0] phase_q,
    output logic [PHASE_W-1:0] phase_nxt,
    output logic               peak_stb
);

    localparam logic [PHASE_W-1:0] CREST = PHASE_W'(HALF_LEN);

    // Next phase: advance with natural wrap while enabled, else restart
    always_comb begin
        phase_nxt = spread_en ? phase_q + 1'b1 : '0;
    end

    // Phase register and crest strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            peak_stb <= 1'b0;
        end else begin
            phase_q  <= phase_nxt;
            peak_stb <= spread_en && (phase_nxt == CREST);
        end
    end

endmodule

// File: rtl/dither_depth_sel.sv
// Holds the active depth. A new depth select is taken only while disabled
// or when the triangle wraps to its zero point, so the slope never changes
// in mid-ramp.
// Assumes: depth_narrow is synchronous to clk.
module dither_depth_sel
    import dither_pkg::*;
#(
    parameter int HALF_LEN = 1024,
    localparam int PHASE_W = $clog2(2 * HALF_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spread_en,
    input  logic               depth_narrow,
    input  logic [PHASE_W-1:0] phase_q,
    output depth_e             depth_q,
    output depth_e             depth_nxt
);

    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(2 * HALF_LEN - 1);

    // Choose whether the pin value is taken on this edge
    always_comb begin
        if (!spread_en || phase_q == LAST) depth_nxt = depth_e'(depth_narrow);
        else                               depth_nxt = depth_q;
    end

    // Active depth register
    always_ff @(posedge clk) begin
        if (!rst_n) depth_q <= DEPTH_WIDE;
        else        depth_q <= depth_nxt;
    end

    // R7
    depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && phase_q != LAST) |=> $stable(depth_q));

endmodule

// File: rtl/dither_shaper.sv
// Folds the phase into a triangle position and scales it by the active
// depth into the registered offset code. Forces zero while disabled.
// Assumes: phase inputs come from dither_phase_ctr with the same HALF_LEN.
module dither_shaper
    import dither_pkg::*;
#(
    parameter int HALF_LEN = 1024,
    localparam int PHASE_W = $clog2(2 * HALF_LEN),
    localparam int CODE_W  = PHASE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spread_en,
    input  logic [PHASE_W-1:0] phase_q,
    input  logic [PHASE_W-1:0] phase_nxt,
    input  depth_e             depth_q,
    input  depth_e             depth_nxt,
    output logic [CODE_W-1:0]  code_q
);

    localparam logic [PHASE_W-1:0] CREST    = PHASE_W'(HALF_LEN);
    localparam logic [PHASE_W-1:0] LAST     = PHASE_W'(2 * HALF_LEN - 1);
    localparam logic [CODE_W-1:0]  FULL     = CODE_W'(2 * HALF_LEN);
    localparam logic [CODE_W-1:0]  PK_NARR  = CODE_W'(HALF_LEN);

    logic [CODE_W-1:0] pos_w;
    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] step_q;
    logic [CODE_W-1:0] peak_q;

    // Fold the phase into a rising then falling position
    always_comb begin
        if (phase_nxt <= CREST) pos_w = CODE_W'(phase_nxt);
        else                    pos_w = FULL - CODE_W'(phase_nxt);
    end

    // Scale by depth: narrow uses the position, wide doubles it
    always_comb begin
        if (!spread_en)                  code_d = '0;
        else if (depth_nxt == DEPTH_NARROW) code_d = pos_w;
        else                             code_d = pos_w << 1;
    end

    // Offset code register
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    // Per-depth step and crest, used only by the checks below
    always_comb begin
        step_q = (depth_q == DEPTH_NARROW) ? CODE_W'(1) : CODE_W'(2);
        peak_q = (depth_q == DEPTH_NARROW) ? PK_NARR : FULL;
    end

    // R2
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && phase_q != LAST) |=>
            (code_q == $past(code_q) + step_q) || (code_q + step_q == $past(code_q)));

    // R5
    one_sided_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= peak_q);

    // R6
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en |=> code_q == '0);

endmodule

// File: rtl/dither_tri_gen.sv
// Top of the triangle dither generator: a one-sided offset code, period
// 2*HALF_LEN master clocks, crest 2*HALF_LEN (4%) or HALF_LEN (2%).
// Assumes: inputs synchronous to clk; HALF_LEN a power of two.
module dither_tri_gen
    import dither_pkg::*;
#(
    parameter int HALF_LEN = 1024,
    localparam int PHASE_W = $clog2(2 * HALF_LEN),
    localparam int CODE_W  = PHASE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spread_en,
    input  logic              depth_narrow,
    output logic [CODE_W-1:0] offset_code,
    output logic              peak_stb
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_nxt;
    depth_e             depth_q;
    depth_e             depth_nxt;

    dither_phase_ctr #(.HALF_LEN(HALF_LEN)) phase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spread_en (spread_en),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt),
        .peak_stb  (peak_stb)
    );

    dither_depth_sel #(.HALF_LEN(HALF_LEN)) depth_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spread_en    (spread_en),
        .depth_narrow (depth_narrow),
        .phase_q      (phase_q),
        .depth_q      (depth_q),
        .depth_nxt    (depth_nxt)
    );

    dither_shaper #(.HALF_LEN(HALF_LEN)) shape_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spread_en (spread_en),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt),
        .depth_q   (depth_q),
        .depth_nxt (depth_nxt),
        .code_q    (offset_code)
    );

    // R8
    crest_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_stb |-> offset_code == ((depth_q == DEPTH_NARROW) ?
                                     CODE_W'(HALF_LEN) : CODE_W'(2 * HALF_LEN)));

endmodule

// File: tb/dither_tri_gen_tb_top.sv
module dither_tri_gen_tb_top;

    localparam int HALF = 1024;
    localparam int PER  = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spread_en = 1'b0;
    logic        depth_narrow = 1'b0;
    logic [11:0] offset_code;
    logic        peak_stb;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit  cmp_on = 1'b0;

    // reference model state, updated from the requirements
    int  m_ph = 0;
    bit  m_nar = 1'b0;
    int  m_code = 0;
    bit  m_stb = 1'b0;

    // run-time trackers
    int  max_code = 0;
    int  last_stb = -1;
    bit  per_on = 1'b0;

    always #10 clk = ~clk;

    dither_tri_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spread_en    (spread_en),
        .depth_narrow (depth_narrow),
        .offset_code  (offset_code),
        .peak_stb     (peak_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // model of R2..R7, advanced on each rising edge
    always @(posedge clk) begin
        int pos;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_nar = 1'b0; m_code = 0; m_stb = 1'b0;
        end else if (!spread_en) begin
            m_ph = 0; m_nar = depth_narrow; m_code = 0; m_stb = 1'b0;
        end else begin
            if (m_ph == PER - 1) m_nar = depth_narrow;
            m_ph = (m_ph + 1) % PER;
            pos = (m_ph <= HALF) ? m_ph : PER - m_ph;
            m_code = m_nar ? pos : 2 * pos;
            m_stb = (m_ph == HALF);
        end
    end

    // compare outputs against the model away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check(cur_req, int'(offset_code), m_code);
            check("R8", int'(peak_stb), int'(m_stb));
            if (int'(offset_code) > max_code) max_code = int'(offset_code);
            if (peak_stb) begin
                if (per_on && last_stb >= 0) check("R8 period", cyc - last_stb, PER);
                last_stb = cyc;
            end
        end
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", int'(offset_code), 0);
        check("R1", int'(peak_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(offset_code), 0);
        cmp_on = 1'b1;

        // R3, R2, R8: wide depth, continuous run
        cur_req = "R3"; per_on = 1'b1; max_code = 0;
        spread_en = 1'b1;
        @(negedge clk);
        check("R6 first step", int'(offset_code), 2);
        repeat (2 * PER + 10) @(negedge clk);
        check("R3 crest", max_code, 2 * HALF);
        per_on = 1'b0; last_stb = -1;

        // R7: request narrow mid-ramp; wide persists until the zero point
        cur_req = "R7";
        depth_narrow = 1'b1;
        repeat (PER) @(negedge clk);
        // R4: narrow depth over full periods
        cur_req = "R4"; max_code = 0; per_on = 1'b1;
        repeat (2 * PER) @(negedge clk);
        check("R4 crest", max_code, HALF);
        per_on = 1'b0; last_stb = -1;

        // R6: drop enable mid-ramp, toggle select while off
        cur_req = "R6";
        spread_en = 1'b0;
        @(negedge clk);
        check("R6 off", int'(offset_code), 0);
        for (int i = 0; i < 10; i++) begin
            depth_narrow = ~depth_narrow;
            @(negedge clk);
            check("R6 held", int'(offset_code), 0);
        end
        depth_narrow = 1'b0;
        @(negedge clk);
        spread_en = 1'b1;
        @(negedge clk);
        check("R6 restart", int'(offset_code), 2);

        // R7: toggle select at scattered phases, including around the crest
        cur_req = "R7";
        for (int k = 0; k < 12; k++) begin
            repeat (97 + 211 * k) @(negedge clk);
            depth_narrow = ~depth_narrow;
        end
        // R5: one-sided bound seen over a mixed run
        cur_req = "R5"; max_code = 0;
        repeat (PER) @(negedge clk);
        check("R5 bound", int'(max_code <= 2 * HALF), 1);

        // R2: short enable bursts restart the ramp
        cur_req = "R2";
        for (int k = 0; k < 6; k++) begin
            spread_en = 1'b0;
            repeat (2) @(negedge clk);
            spread_en = 1'b1;
            repeat (5 + 300 * k) @(negedge clk);
        end

        cmp_on = 1'b0;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule